// File: doc/BRIEF.md
# Serial DAC Control Port

This block receives per-channel volume commands for a stereo audio converter over a three-wire control link. The link has a control clock, a data line and a latch strobe. The block shifts in 16-bit words, most significant bit first. Each word is committed to the left channel, the right channel or both, but only when the latch strobe rises. The committed result is a registered attenuation code and a mute flag for each channel.

The three control wires are asynchronous to the system clock and each passes through a two-flop synchronizer. Edges of the control clock and of the latch strobe are found by edge detection in the system clock domain. Because of this, the control clock may run continuously or be gated between bits and words.

The two word bits above the code select the destination channel. The remaining 14 bits form the attenuation code, in which all ones means full scale and all zeros means mute. A rising edge on the active-low power-down/reset input reloads the defaults and drops any partly shifted word.

Top module: `dac_ctrl_port`

## Requirements
- R1: After the system reset `rst_n`, both attenuation outputs equal 14'h3FFF (full scale) and both mute flags are 0.
- R2: `cdata` is sampled on each rising edge of `cclk`, and the first bit shifted is the word's bit 15 (most significant bit first).
- R3: Shifting changes no output. Outputs change only on a rising edge of `clatch` that follows exactly 16 or more shifted bits, or on a rising edge of `pd_rst_n`.
- R4: In a committed word, bit 15 = 1 writes the right channel and bit 14 = 1 writes the left channel. Both set writes both channels; both clear writes neither.
- R5: Bits 13..0 of a committed word become the attenuation code of each selected channel. That channel's mute flag becomes 1 exactly when the code is 0.
- R6: A latch edge after fewer than 16 shifted bits discards the word, leaving the outputs unchanged. Every latch edge restarts the bit count.
- R7: When more than 16 bits are shifted before a latch edge, the last 16 bits form the word.
- R8: Idle gaps of any length in `cclk`, between bits or between words, neither lose nor add bits.
- R9: A rising edge of `pd_rst_n` returns both channels to 14'h3FFF with mute 0, and discards any partly shifted bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| pd_rst_n | input | 1 | Asynchronous power-down/reset; its rising edge reloads defaults |
| cclk | input | 1 | Control clock; may be gated |
| cdata | input | 1 | Control data, sampled on cclk rising edges |
| clatch | input | 1 | Latch strobe; its rising edge commits the shifted word |
| att_l | output | 14 | Left channel attenuation code |
| att_r | output | 14 | Right channel attenuation code |
| mute_l | output | 1 | Left channel mute flag |
| mute_r | output | 1 | Right channel mute flag |

## Verification
A corrupted bit counter shows up in one of two ways: a short word is accepted, or a full word is refused at the next latch edge. A shifter that slips or reverses the bit order shows up as a wrong code on the selected channel, or as a write to the wrong channel. Each of these faults is visible at the outputs about three system clocks after the latch edge that exposes it. A missed power-down reload leaves a non-default code in place, and a stale partial word then breaks the next short-word test.

// File: rtl/dac_ctrl_port.sv
module dac_ctrl_port #(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pd_rst_n,
  input  logic                cclk,
  input  logic                cdata,
  input  logic                clatch,
  output logic [WORD_W-3:0]   att_l,
  output logic [WORD_W-3:0]   att_r,
  output logic                mute_l,
  output logic                mute_r
);
  localparam int ATT_W = WORD_W - 2;
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);
  localparam logic [ATT_W-1:0] ATT_DEF  = '1;

  logic [SYNC_STAGES:0]   ck_q, lt_q, pd_q;
  logic [SYNC_STAGES-1:0] dt_q;
  logic [WORD_W-1:0]      sh;
  logic [CNT_W-1:0]       cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ck_q <= '0;
      lt_q <= '0;
      pd_q <= '1;
      dt_q <= '0;
    end else begin
      ck_q <= {ck_q[SYNC_STAGES-1:0], cclk};
      lt_q <= {lt_q[SYNC_STAGES-1:0], clatch};
      pd_q <= {pd_q[SYNC_STAGES-1:0], pd_rst_n};
      dt_q <= {dt_q[SYNC_STAGES-2:0], cdata};
    end

  wire ck_rise = ck_q[SYNC_STAGES-1] & ~ck_q[SYNC_STAGES];
  wire lt_rise = lt_q[SYNC_STAGES-1] & ~lt_q[SYNC_STAGES];
  wire pd_rise = pd_q[SYNC_STAGES-1] & ~pd_q[SYNC_STAGES];
  wire din     = dt_q[SYNC_STAGES-1];
  wire take    = lt_rise & (cnt == FULL_CNT);
  wire [ATT_W-1:0] code = sh[ATT_W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
    end else if (pd_rise || lt_rise) begin
      cnt <= '0;
    end else if (ck_rise) begin
      sh <= {sh[WORD_W-2:0], din};
      if (cnt != FULL_CNT) cnt <= cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      att_l  <= ATT_DEF;
      att_r  <= ATT_DEF;
      mute_l <= 1'b0;
      mute_r <= 1'b0;
    end else if (pd_rise) begin
      att_l  <= ATT_DEF;
      att_r  <= ATT_DEF;
      mute_l <= 1'b0;
      mute_r <= 1'b0;
    end else if (take) begin
      if (sh[WORD_W-1]) begin
        att_r  <= code;
        mute_r <= (code == '0);
      end
      if (sh[WORD_W-2]) begin
        att_l  <= code;
        mute_l <= (code == '0);
      end
    end

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_CNT);

  assert_mute_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_l == (att_l == '0)) && (mute_r == (att_r == '0)));

  assert_pd_defaults_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pd_rise |=> (att_l == ATT_DEF) && (att_r == ATT_DEF) && !mute_l && !mute_r && (cnt == '0));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !pd_rise) |=> $stable(att_l) && $stable(att_r) && $stable(mute_l) && $stable(mute_r));

  assert_short_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lt_rise && cnt != FULL_CNT && !pd_rise) |=> $stable(att_l) && $stable(att_r) && (cnt == '0));

  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_rise && !lt_rise && !pd_rise && cnt != FULL_CNT) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: tb/dac_ctrl_port_test.sv
module dac_ctrl_port_test;
  logic clk = 0, rst_n = 0, pd_rst_n = 1, cclk = 0, cdata = 0, clatch = 0;
  logic [13:0] att_l, att_r;
  logic mute_l, mute_r;
  int checks = 0, failures = 0;
  bit done = 0;
  logic [13:0] e_l = 14'h3FFF, e_r = 14'h3FFF;

  always #5 clk = ~clk;

  dac_ctrl_port uut (.clk(clk), .rst_n(rst_n), .pd_rst_n(pd_rst_n), .cclk(cclk),
    .cdata(cdata), .clatch(clatch), .att_l(att_l), .att_r(att_r),
    .mute_l(mute_l), .mute_r(mute_r));

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) begin
      cdata = v[i]; idle(4);
      cclk = 1; idle(4);
      cclk = 0; cdata = ~cdata; idle(2);
    end
  endtask

  task automatic latch();
    clatch = 1; idle(4); clatch = 0; idle(4);
  endtask

  task automatic commit(logic [15:0] w);
    if (w[15]) e_r = w[13:0];
    if (w[14]) e_l = w[13:0];
  endtask

  task automatic check(string req);
    checks++;
    if (att_l !== e_l || att_r !== e_r || mute_l !== (e_l == 0) || mute_r !== (e_r == 0)) begin
      failures++;
      $display("FAIL %s: got l=%h r=%h ml=%b mr=%b exp l=%h r=%h ml=%b mr=%b", req,
        att_l, att_r, mute_l, mute_r, e_l, e_r, e_l == 0, e_r == 0);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    idle(3); rst_n = 1; idle(4);
    check("R1 reset defaults");

    // R2 R4 R5 sweep: channel select x code patterns, MSB-first assembly
    for (int k = 0; k < 96; k++) begin
      logic [15:0] w;
      w = {2'(k % 4), 14'((k * 1237 + 5) % 16384)};
      if (k % 8 == 3) w[13:0] = 14'h0000;
      if (k % 8 == 7) w[13:0] = 14'h3FFF;
      send({16'h0, w}, 16); latch();
      commit(w);
      check("R2 R4 R5 sweep word");
    end

    // R3: full word shifted without latch leaves outputs unchanged
    send(32'h0000C123, 16); idle(10);
    check("R3 no latch no change");
    latch(); commit(16'hC123);
    check("R3 latch commits pending word");

    // R6: short word discarded, count restarts
    send(32'h0000C555, 15); latch();
    check("R6 short word dropped");
    send(32'h00004AAA, 16); latch(); commit(16'h4AAA);
    check("R6 count restarted");

    // R7: extra bits, last 16 used
    send(32'h000F8777, 20); latch(); commit(16'h8777);
    check("R7 last sixteen bits");

    // R8: gated clock with long gap mid-word
    send(32'h000000C0, 8); idle(300); send(32'h00000000, 8); latch(); commit(16'hC000);
    check("R8 gap mid-word, mute both");

    // R9: power-down rising edge reloads defaults and drops partial bits
    send(32'h00000123, 10);
    pd_rst_n = 0; idle(6); pd_rst_n = 1; idle(6);
    e_l = 14'h3FFF; e_r = 14'h3FFF;
    check("R9 defaults on power-down release");
    send(32'h00000001, 6); latch();
    check("R9 partial bits dropped");
    send(32'h00008002, 16); latch(); commit(16'h8002);
    check("R9 operation resumes");

    finish_run();
  end
endmodule